// File: doc/BRIEF.md
# Weighted Supersample Color Combiner

This block turns the colors of several sub-pixel rays into one anti-aliased pixel color. For each pixel it steps through a pattern of sample positions and presents each position to the ray tracer as an offset in X and Y. The offset is in half-pixel units around the pixel center. When the tracer returns the color for the position shown, the block scales each RGB channel by a power-of-two weight and adds it into a per-channel accumulator.

After the last sample of the pattern has been accepted, the block truncates the sums back to the channel width. It presents the result for exactly one cycle and clears the accumulators in the same step.

Two patterns are supported. The dense pattern uses all nine positions of a 3x3 grid. The sparse pattern uses only the center and the four edge-adjacent positions. In both patterns the weights add up to exactly one, and the center sample carries the largest weight. The pattern is chosen per pixel. A pattern request changes the sequence only at a pixel boundary.

Top module: `ss_color_combiner`

## Requirements
- R1: While reset is asserted, and right after it, `pix_valid` is 0 and `smp_idx` is 0.
- R2: With `mode_nine`=1 at the start of a pixel, indices 0..8 present positions in raster order: rows top to bottom, and left to right within a row. Each offset is encoded as a 2-bit two's-complement value in half-pixel units: 2'b11 = -1/2, 2'b00 = 0, 2'b01 = +1/2. `off_y` = 2'b11 is the top row.
- R3: With `mode_nine`=0 at the start of a pixel, indices 0..4 present the positions (0,-1/2), (-1/2,0), (0,0), (+1/2,0), (0,+1/2) in that order. No corner position is ever presented.
- R4: In nine-sample mode each output channel equals floor((4*center + 2*sum of edge samples + sum of corner samples) / 16). Pixel and sample colors are packed as {red[14:10], green[9:5], blue[4:0]}.
- R5: In five-sample mode each output channel equals floor((8*center + 2*sum of edge samples) / 16).
- R6: `pix_valid` is high for exactly one cycle, in the cycle after the final sample of a pixel is accepted, and is low at all other times.
- R7: When all samples of a pixel carry the same color, the output equals that color, including the full-scale value 31 on every channel, with no overflow.
- R8: The level of `mode_nine` while `smp_idx` is not 0 has no effect on the current pixel's offsets, its length or its result.
- R9: A cycle with `smp_valid` low leaves the sample index and the accumulated sums unchanged.
- R10: The three channels are combined independently. A channel that is 0 in every sample gives 0 at the output, whatever the other channels hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_nine | input | 1 | 1 = nine-sample pattern, 0 = five-sample pattern; read when smp_idx is 0 |
| smp_valid | input | 1 | The color on smp_rgb belongs to the presented position |
| smp_rgb | input | 15 | Sample color {R,G,B}, 5 bits each |
| smp_idx | output | 4 | Index of the sample position now presented |
| off_x | output | 2 | X offset of the presented position, half-pixel units |
| off_y | output | 2 | Y offset of the presented position, half-pixel units |
| pix_valid | output | 1 | One-cycle pulse: pix_rgb holds a finished pixel |
| pix_rgb | output | 15 | Combined pixel color {R,G,B} |

## Verification
A slipped sample counter shows up in `smp_idx` and in the offsets on the very next accepted sample. It also moves the `pix_valid` pulse earlier or later than the fifth or ninth sample. A wrong weight shift, or an accumulator that keeps a residue from the previous pixel, appears as a wrong `pix_rgb` in the cycle after the final sample. Uniform-color pixels make such an error stand out as a departure from the input color. Single-channel pixels expose any leakage between channels in the same pulse.

// File: rtl/ssc_pkg.sv
// Package: shared constants and position/weight helpers for the
// supersample combiner. Assumes a 3x3 half-pixel grid, positions numbered
// 0..8 in raster order with 4 as the center.
package ssc_pkg;

    localparam int GRID_POS  = 9;
    localparam int DENSE_N   = 9;
    localparam int SPARSE_N  = 5;
    localparam int IDX_W     = 4;
    localparam int SHIFT_W   = 3;
    localparam int FRAC_W    = 4;   // weights are multiples of 1/16

    typedef logic [1:0] half_off_t; // two's complement, half-pixel units

    // Map a sequence index to a grid position for the chosen pattern.
    function automatic logic [3:0] grid_pos(input logic dense, input logic [IDX_W-1:0] idx);
        logic [3:0] p;
        if (dense) begin
            p = idx;
        end else begin
            case (idx)
                4'd0:    p = 4'd1;
                4'd1:    p = 4'd3;
                4'd2:    p = 4'd4;
                4'd3:    p = 4'd5;
                default: p = 4'd7;
            endcase
        end
        return p;
    endfunction

    // Encode a grid column/row (0,1,2) as a half-pixel offset.
    function automatic half_off_t lane_code(input logic [1:0] lane);
        half_off_t c;
        case (lane)
            2'd0:    c = 2'b11;
            2'd1:    c = 2'b00;
            default: c = 2'b01;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ssc_offset_gen.sv
// Module: ssc_offset_gen
// Walks the sample positions of one pixel and presents the current offset,
// the sample index, the weight shift and an end-of-pixel flag. The pattern
// is taken from mode_i while the index is 0 and held for the rest of the
// pixel. Assumes adv_i is high only when a sample is accepted.
module ssc_offset_gen
    import ssc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic               adv_i,
    output logic [IDX_W-1:0]   idx_o,
    output half_off_t          off_x_o,
    output half_off_t          off_y_o,
    output logic [SHIFT_W-1:0] shift_o,
    output logic               last_o,
    output logic               dense_o
);

    logic [IDX_W-1:0] idx_q;
    logic             dense_q;
    logic             dense_act;
    logic [3:0]       pos;
    logic [1:0]       col;
    logic [1:0]       row;

    // Pattern in force: live request at a pixel boundary, latched otherwise.
    always_comb dense_act = (idx_q == '0) ? mode_i : dense_q;

    // End of pixel: index of the final sample in the active pattern.
    always_comb last_o = (idx_q == (dense_act ? IDX_W'(DENSE_N - 1) : IDX_W'(SPARSE_N - 1)));

    // Sequence counter and pattern latch, both advanced on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            dense_q <= 1'b1;
        end else if (adv_i) begin
            if (idx_q == '0) dense_q <= mode_i;
            idx_q <= last_o ? '0 : idx_q + 1'b1;
        end
    end

    // Split the grid position into column and row.
    always_comb begin
        pos = grid_pos(dense_act, idx_q);
        if (pos < 4'd3)      begin row = 2'd0; col = 2'(pos);          end
        else if (pos < 4'd6) begin row = 2'd1; col = 2'(pos - 4'd3);   end
        else                 begin row = 2'd2; col = 2'(pos - 4'd6);   end
    end

    // Weight as a right shift: center 1/4 or 1/2, edges 1/8, corners 1/16.
    always_comb begin
        if (row == 2'd1 && col == 2'd1)      shift_o = dense_act ? 3'd2 : 3'd1;
        else if (row != 2'd1 && col != 2'd1) shift_o = 3'd4;
        else                                 shift_o = 3'd3;
    end

    // Offset encoding and index outputs.
    always_comb begin
        off_x_o = lane_code(col);
        off_y_o = lane_code(row);
        idx_o   = idx_q;
        dense_o = dense_act;
    end

endmodule

// File: rtl/ssc_channel_acc.sv
// Module: ssc_channel_acc
// One color channel: adds the shifted sample into a fixed-point sum with
// FRAC_W fraction bits and, on the final sample, drops the fraction and
// registers the result while clearing the sum. Assumes the weights of a
// pixel add up to one, so the sum never exceeds the full-scale channel.
module ssc_channel_acc
    import ssc_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_i,
    input  logic               last_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic [CH_W-1:0]    chan_i,
    output logic [CH_W-1:0]    out_o
);

    localparam int ACC_W = CH_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] scaled;
    logic [ACC_W-1:0] sum;

    // Scale by the weight without losing any fraction bits.
    always_comb begin
        scaled = {chan_i, {FRAC_W{1'b0}}} >> shift_i;
        sum    = acc_q + scaled;
    end

    // Accumulate; on the final sample emit the integer part and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            out_o <= '0;
        end else if (add_i) begin
            acc_q <= last_i ? '0 : sum;
            if (last_i) out_o <= sum[ACC_W-1:FRAC_W];
        end
    end

endmodule

// File: rtl/ss_color_combiner.sv
// Module: ss_color_combiner (top)
// Presents sub-pixel offsets, weights each returned RGB sample by a power
// of two, and emits the combined pixel with a one-cycle pulse. Assumes
// samples arrive in the order the offsets are presented.
module ss_color_combiner
    import ssc_pkg::*;
#(
    parameter int CH_W = 5,
    parameter int N_CH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_nine,
    input  logic                 smp_valid,
    input  logic [N_CH*CH_W-1:0] smp_rgb,
    output logic [IDX_W-1:0]     smp_idx,
    output logic [1:0]           off_x,
    output logic [1:0]           off_y,
    output logic                 pix_valid,
    output logic [N_CH*CH_W-1:0] pix_rgb
);

    logic [SHIFT_W-1:0] w_shift;
    logic               last_smp;
    logic               act_nine;
    logic               pix_vq;

    ssc_offset_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_nine),
        .adv_i   (smp_valid),
        .idx_o   (smp_idx),
        .off_x_o (off_x),
        .off_y_o (off_y),
        .shift_o (w_shift),
        .last_o  (last_smp),
        .dense_o (act_nine)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        ssc_channel_acc #(.CH_W(CH_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_i   (smp_valid),
            .last_i  (last_smp),
            .shift_i (w_shift),
            .chan_i  (smp_rgb[ch*CH_W +: CH_W]),
            .out_o   (pix_rgb[ch*CH_W +: CH_W])
        );
    end

    // Pulse the pixel strobe one cycle after the final sample is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_vq <= 1'b0;
        else        pix_vq <= smp_valid & last_smp;
    end

    assign pix_valid = pix_vq;

endmodule

// File: rtl/ssc_checker.sv
// Module: ssc_checker
// Temporal checks on the combiner, attached to every instance by bind.
module ssc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic [3:0] smp_idx,
    input logic [1:0] off_x,
    input logic [1:0] off_y,
    input logic       pix_valid,
    input logic       last_smp,
    input logic       act_nine
);

    // R2: index stays inside the dense pattern, offsets use legal codes
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_idx <= 4'd8) && (off_x != 2'b10) && (off_y != 2'b10));

    // R3: sparse pattern never shows a corner and has five indices
    p_no_corner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !act_nine |-> ((smp_idx <= 4'd4) && !((off_x != 2'b00) && (off_y != 2'b00))));

    // R6: strobe lasts one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    // R6: strobe follows an accepted final sample
    p_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(smp_valid && last_smp));

    // R8: pattern held inside a pixel
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_idx != 4'd0) |-> (act_nine == $past(act_nine)));

    // R9: idle cycles do not advance the sequence
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(smp_idx));

endmodule

bind ss_color_combiner ssc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_idx   (smp_idx),
    .off_x     (off_x),
    .off_y     (off_y),
    .pix_valid (pix_valid),
    .last_smp  (last_smp),
    .act_nine  (act_nine)
);

// File: tb/sim_ss_color_combiner.sv
// Bench: random and directed pixels in both patterns, checked against
// weights and offsets computed from the requirements.
module sim_ss_color_combiner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_nine = 1'b1;
    logic        smp_valid = 1'b0;
    logic [14:0] smp_rgb = '0;
    logic [3:0]  smp_idx;
    logic [1:0]  off_x, off_y;
    logic        pix_valid;
    logic [14:0] pix_rgb;

    int total = 0;
    int bad = 0;
    logic [14:0] cols [9];

    always #2.5 clk = ~clk;

    ss_color_combiner u0 (
        .clk(clk), .rst_n(rst_n), .mode_nine(mode_nine),
        .smp_valid(smp_valid), .smp_rgb(smp_rgb), .smp_idx(smp_idx),
        .off_x(off_x), .off_y(off_y), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pos_of(input bit nine, input int k);
        int sp [5] = '{1, 3, 4, 5, 7};
        return nine ? k : sp[k];
    endfunction

    function automatic logic [1:0] code_of(input int lane);
        return (lane == 0) ? 2'b11 : (lane == 1) ? 2'b00 : 2'b01;
    endfunction

    function automatic int weight16(input bit nine, input int p);
        if (p == 4) return nine ? 4 : 8;
        if ((p % 3) != 1 && (p / 3) != 1) return 1;
        return 2;
    endfunction

    function automatic logic [14:0] expect_pix(input bit nine);
        logic [14:0] r = '0;
        for (int ch = 0; ch < 3; ch++) begin
            int s = 0;
            for (int k = 0; k < (nine ? 9 : 5); k++)
                s += int'((cols[k] >> (ch * 5)) & 15'd31) * weight16(nine, pos_of(nine, k));
            r[ch*5 +: 5] = 5'(s / 16);
        end
        return r;
    endfunction

    task automatic pixel(input bit nine, input int gap_max, input string req);
        int n = nine ? 9 : 5;
        for (int k = 0; k < n; k++) begin
            int gaps = (gap_max == 0) ? 0 : int'($urandom_range(0, gap_max));
            for (int g = 0; g < gaps; g++) begin
                @(negedge clk);
                smp_valid = 1'b0;
                smp_rgb   = 15'($urandom);
                mode_nine = 1'($urandom % 2);
                #1;
                chk(smp_idx == 4'(k), "R9 idle hold idx", smp_idx, k);
                chk(!pix_valid, "R6 no early strobe", pix_valid, 0);
            end
            @(negedge clk);
            smp_valid = 1'b1;
            smp_rgb   = cols[k];
            mode_nine = (k == 0) ? nine : 1'($urandom % 2);
            #1;
            chk(smp_idx == 4'(k), nine ? "R2 index" : "R3 index", smp_idx, k);
            chk(off_x == code_of(pos_of(nine, k) % 3), nine ? "R2 off_x" : "R3 off_x",
                off_x, code_of(pos_of(nine, k) % 3));
            chk(off_y == code_of(pos_of(nine, k) / 3), nine ? "R2 off_y" : "R3 off_y",
                off_y, code_of(pos_of(nine, k) / 3));
            chk(!pix_valid, "R6 no early strobe", pix_valid, 0);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        #1;
        chk(pix_valid, "R6 strobe after final sample", pix_valid, 1);
        chk(pix_rgb == expect_pix(nine), req, pix_rgb, expect_pix(nine));
        @(negedge clk);
        #1;
        chk(!pix_valid, "R6 strobe one cycle", pix_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!pix_valid, "R1 reset strobe", pix_valid, 0);
        chk(smp_idx == 4'd0, "R1 reset index", smp_idx, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(smp_idx == 4'd0 && !pix_valid, "R1 after reset", smp_idx, 0);
        chk(off_x == 2'b11 && off_y == 2'b11, "R2 first dense offset", {off_x, off_y}, 4'b1111);
        mode_nine = 1'b0;
        #1;
        chk(off_x == 2'b00 && off_y == 2'b11, "R3 first sparse offset", {off_x, off_y}, 4'b0011);

        // R7 uniform full scale and zero, both patterns
        for (int k = 0; k < 9; k++) cols[k] = 15'h7FFF;
        pixel(1'b1, 0, "R7 uniform full dense");
        pixel(1'b0, 0, "R7 uniform full sparse");
        for (int k = 0; k < 9; k++) cols[k] = 15'd0;
        pixel(1'b1, 1, "R7 uniform zero dense");
        for (int k = 0; k < 9; k++) cols[k] = {5'd19, 5'd7, 5'd26};
        pixel(1'b0, 2, "R7 uniform mixed sparse");

        // R10 one channel only, each channel in turn
        for (int ch = 0; ch < 3; ch++) begin
            for (int k = 0; k < 9; k++) cols[k] = 15'(($urandom % 32) << (ch * 5));
            pixel(ch != 1, 1, "R10 channel isolation");
        end

        // Center-only and corner-only energy
        for (int k = 0; k < 9; k++) cols[k] = (k == 4) ? 15'h7FFF : 15'd0;
        pixel(1'b1, 0, "R4 center weight dense");
        for (int k = 0; k < 9; k++) cols[k] = (k == 2) ? 15'h7FFF : 15'd0;
        pixel(1'b0, 0, "R5 center weight sparse");
        for (int k = 0; k < 9; k++) cols[k] = (k % 2 == 0 && k != 4) ? 15'h7FFF : 15'd0;
        pixel(1'b1, 0, "R4 corner weights");

        // Random pixels in both patterns; R8 mode toggled mid pixel
        for (int p = 0; p < 60; p++) begin
            bit nine = 1'($urandom % 2);
            for (int k = 0; k < 9; k++) cols[k] = 15'($urandom);
            pixel(nine, 3, nine ? "R4 R8 random dense" : "R5 R8 random sparse");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule